// File: doc/BRIEF.md
# Addressed multi-drop serial receiver

This block receives asynchronous serial frames on a line that many stations share. Each frame has an extra address-marker bit after its eight data bits. When the marker is 1, the frame is an address frame. When it is 0, the frame is a payload frame. The block holds a station address, and the host may change it between frames.

Every address frame is compared with the station address. A clean match opens the station for the payload frames that follow. A mismatch closes it, and the station then ignores payload frames until the next address frame. Accepted payload bytes go to a holding register. The block reports four flags: a byte-ready flag, an overrun flag, a stop-bit (framing) error flag and a parity error flag. The host clears them through two clear strobes.

The line is sampled on a tick that runs at sixteen times the bit rate. A receive enable starts and stops reception. When reception stops, the block forgets any address match.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, rx_data is 0 and all four flags are 0. The station is closed, so a payload frame received before any matching address frame is not accepted.
- R2: A frame is, in order: one low start bit, eight data bits LSB first, the marker bit, an even parity bit (the XOR of the data byte and the parity bit is 0), and one stop bit that should be high. Each bit lasts 16 baud ticks and is sampled near its middle.
- R3: A frame with marker 1 is an address frame. If its byte equals station_id and it has no stop or parity error, the station opens for the payload frames that follow. An address frame never changes rx_data and never sets rdy.
- R4: An address frame that does not match closes the station. Payload frames received while the station is closed change nothing: not rx_data, not rdy, and no error flag.
- R5: A payload frame (marker 0) accepted while rdy is 0 loads its byte into rx_data and sets rdy.
- R6: A payload frame accepted while rdy is 1 sets ovr_err and leaves rx_data unchanged.
- R7: A low stop bit on an address frame, or on an accepted payload frame, sets frm_err.
- R8: A parity mismatch on an address frame, or on an accepted payload frame, sets par_err.
- R9: An address frame whose byte matches station_id but that has a stop or parity error closes the station.
- R10: A pulse on clr_rdy clears rdy. A pulse on clr_err clears ovr_err, frm_err and par_err. If a flag is set and cleared in the same cycle, the set wins.
- R11: While rx_en is low, no frame is received and the station is closed, so after re-enabling only a new matching address frame reopens it. The flags keep their values while rx_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| station_id | input | 8 | This station's address |
| clr_rdy | input | 1 | Clear strobe for rdy |
| clr_err | input | 1 | Clear strobe for the three error flags |
| rx_data | output | 8 | Last accepted payload byte |
| rdy | output | 1 | Byte-ready flag |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Stop-bit error flag |
| par_err | output | 1 | Parity error flag |

## Verification
The embedded assertions check, on every cycle, that:
- address frames leave rx_data unchanged;
- an overrun keeps the stored byte;
- payload frames that arrive while the station is closed leave rdy and the error flags unchanged;
- a disable closes the station;
- the clear strobes take effect.

Only the bench scenarios can show the rest: that bits are sampled and ordered correctly, that a match opens the station and a mismatch or a corrupted address closes it, and that disabling in the middle of a frame forgets the match. The bench checks these against a reference model while it varies addresses, payload bytes, injected stop and parity errors, and the timing of the clear strobes.

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int DW     = 8,
  parameter int OSR    = 16,
  parameter int PAR_EN = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          baud_tick,
  input  logic          rxd,
  input  logic [DW-1:0] station_id,
  input  logic          clr_rdy,
  input  logic          clr_err,
  output logic [DW-1:0] rx_data,
  output logic          rdy,
  output logic          ovr_err,
  output logic          frm_err,
  output logic          par_err
);
  localparam int NB   = DW + 2 + PAR_EN;
  localparam int CW   = $clog2(OSR);
  localparam int IW   = $clog2(NB + 1);
  localparam int HALF = OSR / 2 - 1;

  typedef enum logic [1:0] {IDLE, START, BITS} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [NB-1:0] sh;
  logic          open_q;

  wire          last  = rx_en && baud_tick && st == BITS &&
                        cnt == CW'(OSR - 1) && idx == IW'(NB - 1);
  wire [NB-1:0] frame = {rxd, sh[NB-1:1]};
  wire [DW-1:0] fdata = frame[DW-1:0];
  wire          fmp   = frame[DW];
  wire          fstop_bad = !frame[NB-1];
  logic         fpar_bad;

  generate
    if (PAR_EN != 0) begin : g_par
      assign fpar_bad = ^frame[DW+1:0] ^ fmp;
    end else begin : g_nopar
      assign fpar_bad = 1'b0;
    end
  endgenerate

  wire accept  = last && !fmp && open_q;
  wire err_frm = last && (fmp || open_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; idx <= '0; sh <= '0; open_q <= 1'b0;
    end else if (!rx_en) begin
      st <= IDLE; cnt <= '0; idx <= '0; open_q <= 1'b0;
    end else if (baud_tick) begin
      case (st)
        IDLE: if (!rxd) begin st <= START; cnt <= '0; end
        START: begin
          if (cnt == CW'(HALF)) begin
            st  <= rxd ? IDLE : BITS;
            cnt <= '0;
            idx <= '0;
          end else cnt <= cnt + 1'b1;
        end
        BITS: begin
          if (cnt == CW'(OSR - 1)) begin
            sh  <= frame;
            cnt <= '0;
            if (idx == IW'(NB - 1)) st <= IDLE;
            else idx <= idx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= IDLE;
      endcase
      if (last && fmp) open_q <= (fdata == station_id) && !fstop_bad && !fpar_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0; rdy <= 1'b0; ovr_err <= 1'b0; frm_err <= 1'b0; par_err <= 1'b0;
    end else begin
      if (accept && !rdy) begin
        rx_data <= fdata;
        rdy     <= 1'b1;
      end else if (clr_rdy) rdy <= 1'b0;
      if (accept && rdy) ovr_err <= 1'b1;
      else if (clr_err) ovr_err <= 1'b0;
      if (err_frm && fstop_bad) frm_err <= 1'b1;
      else if (clr_err) frm_err <= 1'b0;
      if (err_frm && fpar_bad) par_err <= 1'b1;
      else if (clr_err) par_err <= 1'b0;
    end
  end

  a_r3_addr_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    last && fmp |=> $stable(rx_data));
  a_r6_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    accept && rdy |=> $stable(rx_data) && ovr_err);
  a_r4_closed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    last && !fmp && !open_q && !clr_rdy && !clr_err |=>
    $stable(rdy) && $stable(frm_err) && $stable(par_err) && $stable(ovr_err));
  a_r11_disable_closes: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !open_q);
  a_r10_clr_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rdy && !accept |=> !rdy);
  a_r10_clr_err: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err && !last |=> !ovr_err && !frm_err && !par_err);
endmodule

// File: tb/mp_uart_rx_test.sv
module mp_uart_rx_test;
  logic clk = 0, rst_n = 0, rx_en = 0, baud_tick = 0, rxd = 1;
  logic [7:0] station_id = 8'h42;
  logic clr_rdy = 0, clr_err = 0;
  logic [7:0] rx_data;
  logic rdy, ovr_err, frm_err, par_err;

  int tests = 0, fails = 0;
  bit done = 0;
  bit e_open = 0, e_rdy = 0, e_ovr = 0, e_fe = 0, e_pe = 0;
  logic [7:0] e_data = 0;

  mp_uart_rx uut (.*);

  always #5 clk = ~clk;
  always @(posedge clk) baud_tick <= ~baud_tick;

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, "rx_data", rx_data, e_data);
    chk(req, "rdy", {7'd0, rdy}, {7'd0, e_rdy});
    chk(req, "ovr_err", {7'd0, ovr_err}, {7'd0, e_ovr});
    chk(req, "frm_err", {7'd0, frm_err}, {7'd0, e_fe});
    chk(req, "par_err", {7'd0, par_err}, {7'd0, e_pe});
  endtask

  task automatic drive_bit(logic b);
    @(negedge clk) rxd = b;
    repeat (31) @(negedge clk);
  endtask

  function automatic void model(logic [7:0] d, bit mp, bit pbad, bit sbad);
    if (mp) begin
      e_fe |= sbad; e_pe |= pbad;
      e_open = (d == station_id) && !sbad && !pbad;
    end else if (e_open) begin
      e_fe |= sbad; e_pe |= pbad;
      if (e_rdy) e_ovr = 1;
      else begin e_data = d; e_rdy = 1; end
    end
  endfunction

  task automatic send(string req, logic [7:0] d, bit mp, bit pbad = 0, bit sbad = 0);
    drive_bit(0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    drive_bit(mp);
    drive_bit((^d) ^ pbad);
    drive_bit(!sbad);
    drive_bit(1);
    model(d, mp, pbad, sbad);
    chk_all(req);
  endtask

  task automatic do_clear(bit r, bit e);
    @(negedge clk) begin clr_rdy = r; clr_err = e; end
    @(negedge clk) begin clr_rdy = 0; clr_err = 0; end
    if (r) e_rdy = 0;
    if (e) begin e_ovr = 0; e_fe = 0; e_pe = 0; end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk_all("R1");
    rst_n = 1;
    @(negedge clk) rx_en = 1;
    repeat (40) @(negedge clk);
    chk_all("R1");

    send("R1", 8'h5A, 0);
    send("R3", 8'h42, 1);
    send("R2", 8'hA5, 0);
    chk("R5", "rx_data", rx_data, 8'hA5);
    send("R6", 8'h3C, 0);
    chk("R6", "ovr_err", {7'd0, ovr_err}, 8'd1);
    do_clear(1, 1);
    chk_all("R10");
    send("R3", 8'h42, 1);
    chk("R3", "rdy", {7'd0, rdy}, 8'd0);
    send("R2", 8'h01, 0);
    do_clear(1, 0);
    send("R4", 8'h17, 1);
    send("R4", 8'h99, 0);
    send("R4", 8'h98, 0, 1, 1);
    send("R3", 8'h42, 1);
    send("R7", 8'h66, 0, 0, 1);
    do_clear(1, 0);
    send("R8", 8'h77, 0, 1, 0);
    do_clear(1, 1);
    send("R9", 8'h42, 1, 1, 0);
    send("R9", 8'h11, 0);
    send("R9", 8'h42, 1, 0, 1);
    send("R9", 8'h12, 0);
    do_clear(0, 1);

    send("R11", 8'h42, 1);
    send("R11", 8'h44, 0, 0, 1);
    drive_bit(0); drive_bit(1); drive_bit(0);
    @(negedge clk) rx_en = 0;
    rxd = 1;
    repeat (100) @(negedge clk);
    e_open = 0;
    chk_all("R11");
    @(negedge clk) rx_en = 1;
    drive_bit(1);
    send("R11", 8'h55, 0);
    do_clear(1, 1);

    for (int n = 0; n < 150; n++) begin
      bit mp = ($urandom % 3) == 0;
      logic [7:0] d = mp && ($urandom % 2) ? station_id : 8'($urandom);
      bit sb = ($urandom % 14) == 0;
      bit pb = ($urandom % 14) == 0;
      send(mp ? "R3" : "R5", d, mp, pb, sb);
      if ($urandom % 2) do_clear(1, ($urandom % 4) == 0);
      if (($urandom % 20) == 0) station_id = 8'($urandom);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule